// File: doc/BRIEF.md
# PWM Duty Fade Engine

This block is a single-channel pulse-width modulator that changes its own duty over time. Software writes one 32-bit configuration word. The word holds a step size, a step interval counted in PWM periods, a number of steps and a direction. While its start bit is clear, the word is only staged and has no effect. Writing the word with the start bit set hands the staged values to the ramp engine. The engine then adds the step size to the duty, or subtracts it, once per interval until the step count runs out.

The PWM period counter is free-running and has `2**CNT_W` states. The output is high while the counter is below the duty that is active for the current period. A duty computed by the ramp is copied into the compare register only at a period boundary, so a period never carries two compare values. During a ramp the block drives a busy flag. It raises a one-cycle done pulse when the last step lands. The duty is clamped at zero and at full scale, where full scale is a constantly high output.

Top module: `fade_pwm`

## Requirements
- R1: After reset the read-back word is 0x4000_0000, and `duty_o`, `busy`, `done` and `pwm_out` are all 0.
- R2: Fields of the configuration word: bit 31 start, bit 30 direction (1 = up), bits 29:20 step count, bits 19:10 interval, bits 9:0 step size. The read-back returns the last written word with bit 31 always 0.
- R3: A write with bit 31 clear leaves a running ramp unchanged: same step size, interval, count and direction.
- R4: A start write is sampled on a clock edge. `busy` rises after the second rising edge that follows, and is still low after the first.
- R5: Each step changes `duty_o` by the step size: upward when the direction bit is 1, downward when it is 0.
- R6: With an interval of N, a step lands on every Nth period boundary after the start, and `duty_o` holds its value between steps. An interval of 0 behaves as 1.
- R7: `busy` stays high until the last of the counted steps. On the boundary where that step lands, `busy` falls and `done` is high for exactly one cycle.
- R8: `duty_o` never goes below 0 or above `2**CNT_W`. A step that would pass a limit stops at the limit and still uses up one step.
- R9: A start with a step count of 0 raises `done` for one cycle at the moment `busy` would have risen. `busy` stays low and the duty does not change.
- R10: A start during a running ramp drops the old parameters. The new ramp continues from the present duty, and its interval timing restarts.
- R11: In each period, `pwm_out` is high for exactly as many cycles as the duty that was present at the boundary opening that period. `pwm_out` rises only when `pwm_cnt` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Write strobe for the configuration word |
| cfg_wdata | input | 32 | Configuration word being written |
| cfg_rdata | output | 32 | Staged configuration word, start bit reads 0 |
| pwm_cnt | output | CNT_W | PWM period counter |
| pwm_out | output | 1 | PWM output |
| duty_o | output | CNT_W+1 | Duty value produced by the ramp |
| busy | output | 1 | Ramp in progress |
| done | output | 1 | One-cycle pulse when a ramp finishes |

## Verification
The hardest case to reach is a restart or a staged write that arrives while a ramp is partway through its steps. The case has to be told apart from a normal finish, and a period boundary must not fall on the same edges as the write. The driver therefore makes every write in the middle of a period. It waits a chosen number of boundaries into a running ramp, then stages a write without start, or issues a new start. The scoreboard drops the unfinished expectations of an interrupted ramp and builds the new ones from the duty seen at the ports. The clamp cases are reached by chaining ramps, so that one ramp begins where the previous one ended, close to a limit.

// File: rtl/fade_pkg.sv
package fade_pkg;
   localparam int FLD_W = 10;
   localparam logic [31:0] CFG_RESET = 32'h4000_0000;

   typedef struct packed {
      logic             start;
      logic             up;
      logic [FLD_W-1:0] count;
      logic [FLD_W-1:0] intv;
      logic [FLD_W-1:0] scale;
   } cfg_word_t;
endpackage

// File: rtl/fade_cfg_stage.sv
module fade_cfg_stage
   import fade_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        we,
   input  logic [31:0] wdata,
   output cfg_word_t   cfg_q,
   output logic        start_q
);
   cfg_word_t cfg_d;

   always_comb begin
      cfg_d       = cfg_word_t'(wdata);
      cfg_d.start = 1'b0;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q   <= cfg_word_t'(CFG_RESET);
         start_q <= 1'b0;
      end else begin
         start_q <= we & wdata[31];
         if (we) cfg_q <= cfg_d;
      end
   end
endmodule

// File: rtl/fade_ramp.sv
module fade_ramp
   import fade_pkg::*;
#(
   parameter int CNT_W  = 10,
   parameter int DUTY_W = CNT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  cfg_word_t         cfg,
   input  logic              period_end,
   output logic [DUTY_W-1:0] duty,
   output logic              busy,
   output logic              done
);
   localparam int SUM_W = ((DUTY_W > FLD_W) ? DUTY_W : FLD_W) + 1;
   localparam logic [SUM_W-1:0] FULL_EXT = {{(SUM_W-1){1'b0}}, 1'b1} << CNT_W;

   logic [FLD_W-1:0] scale_q, intv_q, left_q, tick_q;
   logic             up_q;
   logic [SUM_W-1:0] d_ext, s_ext, sum_up;
   logic [DUTY_W-1:0] nxt_up, nxt_dn, nxt;
   logic             last_tick;

   always_comb begin
      d_ext  = SUM_W'(duty);
      s_ext  = SUM_W'(scale_q);
      sum_up = d_ext + s_ext;
      nxt_up = (sum_up > FULL_EXT) ? FULL_EXT[DUTY_W-1:0] : sum_up[DUTY_W-1:0];
      nxt_dn = (d_ext >= s_ext) ? DUTY_W'(d_ext - s_ext) : '0;
      nxt    = up_q ? nxt_up : nxt_dn;
      last_tick = ((tick_q + FLD_W'(1)) == intv_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scale_q <= '0;
         intv_q  <= FLD_W'(1);
         left_q  <= '0;
         tick_q  <= '0;
         up_q    <= 1'b1;
         duty    <= '0;
         busy    <= 1'b0;
         done    <= 1'b0;
      end else begin
         done <= 1'b0;
         if (start) begin
            scale_q <= cfg.scale;
            up_q    <= cfg.up;
            intv_q  <= (cfg.intv == '0) ? FLD_W'(1) : cfg.intv;
            left_q  <= cfg.count;
            tick_q  <= '0;
            if (cfg.count == '0) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               busy <= 1'b1;
            end
         end else if (busy && period_end) begin
            if (last_tick) begin
               tick_q <= '0;
               duty   <= nxt;
               left_q <= left_q - FLD_W'(1);
               if (left_q == FLD_W'(1)) begin
                  busy <= 1'b0;
                  done <= 1'b1;
               end
            end else begin
               tick_q <= tick_q + FLD_W'(1);
            end
         end
      end
   end
endmodule

// File: rtl/fade_pwm_core.sv
module fade_pwm_core #(
   parameter int CNT_W  = 10,
   parameter int DUTY_W = CNT_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DUTY_W-1:0] duty_tgt,
   output logic [CNT_W-1:0]  cnt,
   output logic              period_end,
   output logic              pwm_out
);
   logic [DUTY_W-1:0] duty_act;

   assign period_end = &cnt;
   assign pwm_out    = ({1'b0, cnt} < duty_act);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt      <= '0;
         duty_act <= '0;
      end else begin
         cnt <= cnt + CNT_W'(1);
         if (period_end) duty_act <= duty_tgt;
      end
   end
endmodule

// File: rtl/fade_pwm.sv
module fade_pwm
   import fade_pkg::*;
#(
   parameter int CNT_W = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             cfg_we,
   input  logic [31:0]      cfg_wdata,
   output logic [31:0]      cfg_rdata,
   output logic [CNT_W-1:0] pwm_cnt,
   output logic             pwm_out,
   output logic [CNT_W:0]   duty_o,
   output logic             busy,
   output logic             done
);
   localparam int DUTY_W = CNT_W + 1;

   generate
      if (CNT_W < 2 || CNT_W > 16) begin : g_bad_cnt_w
         $error("fade_pwm: CNT_W must lie in 2..16");
      end
   endgenerate

   cfg_word_t         cfg_q;
   logic              start_q;
   logic              period_end;
   logic [DUTY_W-1:0] duty_w;

   fade_cfg_stage u_stage (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (cfg_we),
      .wdata   (cfg_wdata),
      .cfg_q   (cfg_q),
      .start_q (start_q)
   );

   fade_ramp #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_ramp (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start_q),
      .cfg        (cfg_q),
      .period_end (period_end),
      .duty       (duty_w),
      .busy       (busy),
      .done       (done)
   );

   fade_pwm_core #(.CNT_W(CNT_W), .DUTY_W(DUTY_W)) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .duty_tgt   (duty_w),
      .cnt        (pwm_cnt),
      .period_end (period_end),
      .pwm_out    (pwm_out)
   );

   assign cfg_rdata = cfg_q;
   assign duty_o    = duty_w;
endmodule

// File: rtl/fade_pwm_chk.sv
module fade_pwm_chk #(
   parameter int CNT_W = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic [31:0]      cfg_rdata,
   input logic [CNT_W-1:0] pwm_cnt,
   input logic             pwm_out,
   input logic [CNT_W:0]   duty_o,
   input logic             busy,
   input logic             done
);
   localparam logic [CNT_W:0] FULL = {1'b1, {CNT_W{1'b0}}};

   a_r2_start_reads_low: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_rdata[31]);

   a_r8_duty_in_range: assert property (@(posedge clk) disable iff (!rst_n)
      duty_o <= FULL);

   a_r7_busy_fall_has_done: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> done);

   a_r7_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);

   a_r11_rise_at_boundary: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(pwm_out) |-> (pwm_cnt == '0));

   a_r5_duty_moves_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(duty_o) |-> $past(busy));
endmodule

bind fade_pwm fade_pwm_chk #(.CNT_W(CNT_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cfg_rdata (cfg_rdata),
   .pwm_cnt   (pwm_cnt),
   .pwm_out   (pwm_out),
   .duty_o    (duty_o),
   .busy      (busy),
   .done      (done)
);

// File: tb/fade_pwm_tb_top.sv
module fade_pwm_tb_top;
   localparam int CLK_PERIOD = 10;
   localparam int CNT_W = 4;
   localparam int PER   = 1 << CNT_W;
   localparam int HALF  = PER / 2;
   localparam int FULL  = PER;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             cfg_we = 1'b0;
   logic [31:0]      cfg_wdata = '0;
   logic [31:0]      cfg_rdata;
   logic [CNT_W-1:0] pwm_cnt;
   logic             pwm_out;
   logic [CNT_W:0]   duty_o;
   logic             busy;
   logic             done;

   always #(CLK_PERIOD/2) clk = ~clk;

   fade_pwm #(.CNT_W(CNT_W)) dut_i (
      .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
      .cfg_rdata(cfg_rdata), .pwm_cnt(pwm_cnt), .pwm_out(pwm_out),
      .duty_o(duty_o), .busy(busy), .done(done)
   );

   typedef struct {int duty; bit last;} exp_t;
   exp_t exp_q[$];

   int  n_chk = 0;
   int  n_fail = 0;
   bit  armed = 1'b0;
   int  cur_intv = 1;
   int  nb = 0;
   int  prev_duty = 0;
   bit  chk_done_low = 1'b0;
   bit  finished = 1'b0;

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic summary();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   function automatic int step_val(input int d, input int s, input bit up);
      if (up) return (d + s > FULL) ? FULL : d + s;
      return (d > s) ? d - s : 0;
   endfunction

   function automatic logic [31:0] word(input bit st, input bit up, input int n,
                                        input int iv, input int sc);
      return {st, up, 10'(n), 10'(iv), 10'(sc)};
   endfunction

   // write in mid-period; returns at the negedge after the sampling edge
   task automatic wr(input logic [31:0] w);
      do @(negedge clk); while (pwm_cnt !== CNT_W'(HALF));
      cfg_we    = 1'b1;
      cfg_wdata = w;
      @(negedge clk);
      cfg_we    = 1'b0;
   endtask

   task automatic launch(input int sc, input int iv, input int n, input bit up);
      logic [31:0] w;
      bit busy_before;
      int pre, d;
      w = word(1'b1, up, n, iv, sc);
      armed = 1'b0;
      exp_q.delete();
      busy_before = busy;
      pre = int'(duty_o);
      wr(w);
      chk(cfg_rdata == (w & 32'h7FFF_FFFF), "R2 readback", int'(cfg_rdata), int'(w & 32'h7FFF_FFFF));
      if (!busy_before) chk(busy == 1'b0, "R4 busy after first edge", busy, 0);
      @(negedge clk);
      chk(busy == (n != 0), "R4 busy after second edge", busy, (n != 0));
      if (n == 0) begin
         chk(done == 1'b1, "R9 done pulse", done, 1);
         chk(int'(duty_o) == pre, "R9 duty unchanged", int'(duty_o), pre);
         @(negedge clk);
         chk(done == 1'b0, "R9 done one cycle", done, 0);
         chk(busy == 1'b0, "R9 stays idle", busy, 0);
         return;
      end
      d = int'(duty_o);
      prev_duty = d;
      for (int i = 0; i < n; i++) begin
         exp_t e;
         d = step_val(d, sc, up);
         e.duty = d;
         e.last = (i == n - 1);
         exp_q.push_back(e);
      end
      cur_intv = (iv == 0) ? 1 : iv;
      nb = 0;
      armed = 1'b1;
   endtask

   task automatic wait_idle();
      while (armed) @(negedge clk);
      @(negedge clk);
   endtask

   task automatic wait_bounds(input int n);
      for (int i = 0; i < n; i++) begin
         do @(negedge clk); while (pwm_cnt != '0);
      end
   endtask

   // monitor: step scoreboard and PWM high-time check
   int hc = 0, dh1 = 0, dh2 = 0, nbound = 0;
   initial begin
      forever begin
         @(negedge clk);
         if (rst_n) begin
            if (chk_done_low) begin
               chk(done == 1'b0, "R7 done one cycle", done, 0);
               chk_done_low = 1'b0;
            end
            if (pwm_cnt == '0) begin
               if (nbound >= 2) chk(hc == dh2, "R11 high cycles per period", hc, dh2);
               dh2 = dh1;
               dh1 = int'(duty_o);
               hc  = int'(pwm_out);
               nbound++;
               if (armed) begin
                  nb++;
                  if (nb % cur_intv == 0) begin
                     if (exp_q.size() == 0) begin
                        chk(1'b0, "R7 unexpected step", int'(duty_o), -1);
                        armed = 1'b0;
                     end else begin
                        exp_t e;
                        e = exp_q.pop_front();
                        chk(int'(duty_o) == e.duty, "R5 R8 step value", int'(duty_o), e.duty);
                        chk(busy == !e.last, "R7 busy", busy, !e.last);
                        chk(done == e.last, "R7 done", done, e.last);
                        prev_duty = e.duty;
                        if (e.last) begin
                           armed = 1'b0;
                           chk_done_low = 1'b1;
                        end
                     end
                  end else begin
                     chk(int'(duty_o) == prev_duty, "R6 hold between steps", int'(duty_o), prev_duty);
                     chk(busy == 1'b1, "R6 busy between steps", busy, 1);
                  end
               end
            end else begin
               hc += int'(pwm_out);
            end
         end
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(cfg_rdata == 32'h4000_0000, "R1 readback", int'(cfg_rdata), 32'h4000_0000);
      chk(duty_o == '0, "R1 duty", int'(duty_o), 0);
      chk(busy == 1'b0, "R1 busy", busy, 0);
      chk(done == 1'b0, "R1 done", done, 0);
      chk(pwm_out == 1'b0, "R1 pwm", pwm_out, 0);

      // R5 up ramp, interval 1: 3,6,9,12
      launch(3, 1, 4, 1'b1);
      wait_idle();
      // R8 low clamp, interval 2: 7,2,0,0
      launch(5, 2, 4, 1'b0);
      wait_idle();
      // R6 interval 0 acts as 1, R8 high clamp: 7,14,16,16
      launch(7, 0, 4, 1'b1);
      wait_idle();
      // R3 staged write during a ramp has no effect: 15,14,13
      launch(1, 3, 3, 1'b0);
      wait_bounds(1);
      wr(word(1'b0, 1'b1, 2, 1, 9));
      chk(cfg_rdata == word(1'b0, 1'b1, 2, 1, 9), "R3 R2 staged readback",
          int'(cfg_rdata), int'(word(1'b0, 1'b1, 2, 1, 9)));
      chk(busy == 1'b1, "R3 ramp continues", busy, 1);
      wait_idle();
      chk(int'(duty_o) == 13, "R3 final duty", int'(duty_o), 13);
      // R10 restart mid-ramp: down from 13 by 2, then up by 1 twice
      launch(2, 1, 6, 1'b0);
      wait_bounds(2);
      launch(1, 1, 2, 1'b1);
      wait_idle();
      chk(int'(duty_o) == 11, "R10 final duty", int'(duty_o), 11);
      // R8 oversize step clamps at full scale
      launch(1023, 2, 2, 1'b1);
      wait_idle();
      // R9 zero count
      launch(4, 1, 0, 1'b1);
      wait_bounds(3);
      summary();
   end
endmodule